// File: doc/BRIEF.md
# Quad Lookup-Table Trigger Engine

This block decides, sample by sample, whether a 16-channel logic-analyzer stream has met a programmed trigger condition. The channels are split into four quads of four. The levels of each quad address that quad's small truth tables. One table gives a value/mask match. Two more give edge-condition inputs. The per-quad answers are ANDed across the quads. A combining table turns current and previous condition bits into an edge verdict, and a final table merges the level match, the edge verdict, an auxiliary bit and a history flag. A qualifying counter with two compare values then decides whether the final verdict actually fires.

Configuration comes through a byte-wide write port with two addresses. Data bytes enter a short byte history. A control write then either commits the two newest bytes to one table address, commits the five newest bytes as counter parameters, or holds or releases the engine. The control state machine has three states. HELD is the reset state, in which samples are ignored and history and counter stay cleared. ARMED is the state in which samples are evaluated. FIRED is entered after the pulse and ignores everything until the next hold. Its transitions are *release* (HELD to ARMED, on a control write with the hold bit clear), *trip* (ARMED to FIRED, on a firing sample) and *hold* (ARMED or FIRED to HELD, on a control write with the hold bit set).

Top module: `lut_trigger_core`

## Requirements
- R1: After reset the engine is HELD, `trig_o` is low and every table is zero, so no sample pattern fires, even after release.
- R2: Writes with `cfg_addr_i`=0 push a data byte. Writes with `cfg_addr_i`=1 are control bytes: bit 5 holds (1) or releases (0), bit 4 commits a table address, bit 6 commits parameters, and bits 3:0 give the table address.
- R3: A table commit stores, at the given address, the older of the two newest data bytes as {unused, final, auxiliary, combining, level bits of quads 3..0} (bits 7..0). It stores the newest byte as {edge-1 bits of quads 3..0, edge-0 bits of quads 3..0}.
- R4: Quad q is addressed by channels 4q+3..4q (channel 4q is address bit 0). The level match is the AND of the four quads' level-table bits.
- R5: The edge-0 and edge-1 conditions are ANDs of their quad tables. The combining table is indexed by {previous edge-1, edge-1, previous edge-0, edge-0} (bits 3..0), and the previous values are captured on every accepted sample.
- R6: The final table is indexed by {level, combining, auxiliary, history} (bits 3..0). History is 1 once a sample has been accepted since the last hold.
- R7: A parameter commit takes the five newest data bytes as selector low byte, compare B (big-endian) and compare A (big-endian). In the selector, bits 7:6 are the increment source, bits 5:4 the reset source and bits 3:2 the fire mode. Source codes are 0 always, 1 final hit, 2 combining hit and 3 never.
- R8: On each accepted sample, the counter is cleared if the reset source is true. Otherwise it increments, saturating, if the increment source is true.
- R9: Fire modes, evaluated with the counter value before the update: 0 is final hit and count >= A; 1 is count >= A; 2 is final hit and count >= B; 3 is never. With mode 0 and A=0, the first final hit fires.
- R10: `trig_o` is a one-cycle registered pulse in the cycle after the firing sample is taken. It fires once per arm, and firing again needs a hold followed by a release.
- R11: While HELD, samples are ignored and history and counter stay cleared. A hold write in the same cycle as a firing sample suppresses the pulse.
- R12: After reset the parameters are: increment on final hit, never reset, fire mode 0, and both compares zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_data_i | input | 16 | Channel levels, channel n on bit n |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 data byte, 1 control byte |
| cfg_wdata_i | input | 8 | Configuration byte |
| trig_o | output | 1 | Trigger pulse |

## Verification
A control write that sets the hold bit and a sample that would fire can land in the same cycle. That is where the engine's two paths, configuration and evaluation, meet. The bench arms a single-channel level trigger and takes one sample so that history is set. It then drives the hold write and a matching sample on the same edge and requires that no pulse follows. After a fresh release it requires that the next matching sample still does not fire, because history was cleared, and that the sample after it does fire.

// File: rtl/ltrg_pkg.sv
package ltrg_pkg;

    localparam int QUAD_W  = 4;
    localparam int N_QUADS = 4;
    localparam int N_CH    = QUAD_W * N_QUADS;
    localparam int LUT_D   = 1 << QUAD_W;
    localparam int BYTE_W  = 8;
    localparam int CMP_W   = 16;
    localparam int HIST_W  = BYTE_W + 2 * CMP_W;

    // control byte fields
    localparam int CTL_PARLD = 6;
    localparam int CTL_HOLD  = 5;
    localparam int CTL_LUTWR = 4;

    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } trig_state_e;

    typedef enum logic [1:0] {
        SRC_ALWAYS = 2'd0,
        SRC_FINAL  = 2'd1,
        SRC_COMB   = 2'd2,
        SRC_NEVER  = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        FM_HIT_A = 2'd0,
        FM_CNT_A = 2'd1,
        FM_HIT_B = 2'd2,
        FM_OFF   = 2'd3
    } fire_mode_e;

    typedef struct packed {
        src_sel_e   inc;
        src_sel_e   rst;
        fire_mode_e mode;
    } qual_sel_t;

    // bit order equals the two committed bytes, bits 14..0
    typedef struct packed {
        logic               f4;
        logic               aux;
        logic               comb;
        logic [N_QUADS-1:0] m2;
        logic [N_QUADS-1:0] m1;
        logic [N_QUADS-1:0] m0;
    } lut_bits_t;

endpackage

// File: rtl/ltrg_cfg_port.sv
module ltrg_cfg_port
    import ltrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              hold_q_o,
    output logic              hold_set_o,
    output logic              release_o,
    output logic              tbl_we_o,
    output logic [QUAD_W-1:0] tbl_addr_o,
    output lut_bits_t         tbl_bits_o,
    output qual_sel_t         qsel_o,
    output logic [CMP_W-1:0]  cmpa_o,
    output logic [CMP_W-1:0]  cmpb_o
);

    localparam int TBL_BITS = $bits(lut_bits_t);

    logic [HIST_W-1:0] hist_q;
    logic              hold_q;
    qual_sel_t         qsel_q;
    logic [CMP_W-1:0]  cmpa_q, cmpb_q;
    logic              ctl_wr, dat_wr, par_wr;
    logic [BYTE_W-1:0] sel_b;
    logic              unused_cfg;

    assign ctl_wr = we_i &&  addr_i;
    assign dat_wr = we_i && !addr_i;
    assign par_wr = ctl_wr && wdata_i[CTL_PARLD];
    assign sel_b  = hist_q[HIST_W-1 -: BYTE_W];

    // byte history, newest byte in the low bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hist_q <= '0;
        else if (dat_wr) hist_q <= {hist_q[HIST_W-BYTE_W-1:0], wdata_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= 1'b1;
        else if (ctl_wr) hold_q <= wdata_i[CTL_HOLD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qsel_q <= '{inc: SRC_FINAL, rst: SRC_NEVER, mode: FM_HIT_A};
            cmpa_q <= '0;
            cmpb_q <= '0;
        end else if (par_wr) begin
            qsel_q.inc  <= src_sel_e'(sel_b[7:6]);
            qsel_q.rst  <= src_sel_e'(sel_b[5:4]);
            qsel_q.mode <= fire_mode_e'(sel_b[3:2]);
            cmpb_q      <= hist_q[2*CMP_W-1:CMP_W];
            cmpa_q      <= hist_q[CMP_W-1:0];
        end
    end

    assign hold_q_o   = hold_q;
    assign hold_set_o = ctl_wr &&  wdata_i[CTL_HOLD];
    assign release_o  = ctl_wr && !wdata_i[CTL_HOLD];
    assign tbl_we_o   = ctl_wr &&  wdata_i[CTL_LUTWR];
    assign tbl_addr_o = wdata_i[QUAD_W-1:0];
    assign tbl_bits_o = lut_bits_t'(hist_q[TBL_BITS-1:0]);
    assign qsel_o     = qsel_q;
    assign cmpa_o     = cmpa_q;
    assign cmpb_o     = cmpb_q;
    assign unused_cfg = ^{hist_q[2*BYTE_W-1], sel_b[1:0]};

    p_param_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_wr |=> (cmpa_o == $past(hist_q[CMP_W-1:0])) &&
                   (cmpb_o == $past(hist_q[2*CMP_W-1:CMP_W])));

    p_hold_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> hold_q_o == $past(wdata_i[CTL_HOLD]));

endmodule

// File: rtl/ltrg_quad_lut.sv
module ltrg_quad_lut
    import ltrg_pkg::*;
#(
    parameter int AW = QUAD_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [2:0]    wbits_i,
    input  logic [AW-1:0] raddr_i,
    output logic          lvl_o,
    output logic          c0_o,
    output logic          c1_o
);

    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] lvl_q, c1_q, c0_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            c1_q  <= '0;
            c0_q  <= '0;
        end else if (we_i) begin
            lvl_q[waddr_i] <= wbits_i[2];
            c1_q[waddr_i]  <= wbits_i[1];
            c0_q[waddr_i]  <= wbits_i[0];
        end
    end

    assign lvl_o = lvl_q[raddr_i];
    assign c1_o  = c1_q[raddr_i];
    assign c0_o  = c0_q[raddr_i];

    p_tbl_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (lvl_q[$past(waddr_i)] == $past(wbits_i[2])) &&
                 (c1_q[$past(waddr_i)]  == $past(wbits_i[1])) &&
                 (c0_q[$past(waddr_i)]  == $past(wbits_i[0])));

endmodule

// File: rtl/ltrg_combiner.sv
module ltrg_combiner
    import ltrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [QUAD_W-1:0] waddr_i,
    input  logic [2:0]        wbits_i,   // {final, aux, comb}
    input  logic              take_i,
    input  logic              clr_i,
    input  logic              lvl_i,
    input  logic              c0_i,
    input  logic              c1_i,
    output logic              comb_o,
    output logic              final_o
);

    logic [LUT_D-1:0]  comb_q, aux_q, fin_q;
    logic              c0p_q, c1p_q, hist_q;
    logic [QUAD_W-1:0] e_idx, f_idx;
    logic              aux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comb_q <= '0;
            aux_q  <= '0;
            fin_q  <= '0;
        end else if (we_i) begin
            fin_q[waddr_i]  <= wbits_i[2];
            aux_q[waddr_i]  <= wbits_i[1];
            comb_q[waddr_i] <= wbits_i[0];
        end
    end

    // previous condition bits and history flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c0p_q  <= 1'b0;
            c1p_q  <= 1'b0;
            hist_q <= 1'b0;
        end else if (clr_i) begin
            c0p_q  <= 1'b0;
            c1p_q  <= 1'b0;
            hist_q <= 1'b0;
        end else if (take_i) begin
            c0p_q  <= c0_i;
            c1p_q  <= c1_i;
            hist_q <= 1'b1;
        end
    end

    assign e_idx   = {c1p_q, c1_i, c0p_q, c0_i};
    assign comb_o  = comb_q[e_idx];
    assign aux     = aux_q[e_idx];
    assign f_idx   = {lvl_i, comb_o, aux, hist_q};
    assign final_o = fin_q[f_idx];

    p_prev_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !clr_i) |=> (c0p_q == $past(c0_i)) && (c1p_q == $past(c1_i)) && hist_q);

    p_clear_hist_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hist_q && !c0p_q && !c1p_q);

endmodule

// File: rtl/ltrg_qual_counter.sv
module ltrg_qual_counter
    import ltrg_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic             final_i,
    input  logic             comb_i,
    input  qual_sel_t        qsel_i,
    input  logic [CMP_W-1:0] cmpa_i,
    input  logic [CMP_W-1:0] cmpb_i,
    output logic             fire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             inc_hit, rst_hit, ge_a, ge_b, cond;

    function automatic logic pick(input src_sel_e s, input logic fin, input logic cmb);
        logic r;
        unique case (s)
            SRC_ALWAYS: r = 1'b1;
            SRC_FINAL:  r = fin;
            SRC_COMB:   r = cmb;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    assign inc_hit = pick(qsel_i.inc, final_i, comb_i);
    assign rst_hit = pick(qsel_i.rst, final_i, comb_i);
    assign ge_a    = cnt_q >= CNT_W'(cmpa_i);
    assign ge_b    = cnt_q >= CNT_W'(cmpb_i);

    always_comb begin
        unique case (qsel_i.mode)
            FM_HIT_A: cond = final_i && ge_a;
            FM_CNT_A: cond = ge_a;
            FM_HIT_B: cond = final_i && ge_b;
            default:  cond = 1'b0;
        endcase
    end

    assign fire_o = take_i && cond;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (clr_i)                        cnt_q <= '0;
        else if (take_i && rst_hit)            cnt_q <= '0;
        else if (take_i && inc_hit && ~&cnt_q) cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (cnt_q == '0) || (cnt_q == $past(cnt_q)) ||
                   (cnt_q == $past(cnt_q) + 1'b1));

    p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lut_trigger_core.sv
module lut_trigger_core
    import ltrg_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid_i,
    input  logic [N_CH-1:0]   smp_data_i,
    input  logic              cfg_we_i,
    input  logic              cfg_addr_i,
    input  logic [BYTE_W-1:0] cfg_wdata_i,
    output logic              trig_o
);

    trig_state_e       state_q, state_d;
    logic              hold_q, hold_set, release_w;
    logic              tbl_we;
    logic [QUAD_W-1:0] tbl_addr;
    lut_bits_t         tbl_bits;
    qual_sel_t         qsel;
    logic [CMP_W-1:0]  cmpa, cmpb;
    logic [N_QUADS-1:0] lvl_v, c0_v, c1_v;
    logic              take, clr, comb_hit, final_hit, fire, trig_d, trig_q;

    ltrg_cfg_port u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .addr_i     (cfg_addr_i),
        .wdata_i    (cfg_wdata_i),
        .hold_q_o   (hold_q),
        .hold_set_o (hold_set),
        .release_o  (release_w),
        .tbl_we_o   (tbl_we),
        .tbl_addr_o (tbl_addr),
        .tbl_bits_o (tbl_bits),
        .qsel_o     (qsel),
        .cmpa_o     (cmpa),
        .cmpb_o     (cmpb)
    );

    for (genvar q = 0; q < N_QUADS; q++) begin : g_quad
        ltrg_quad_lut #(.AW(QUAD_W)) u_lut (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (tbl_we),
            .waddr_i (tbl_addr),
            .wbits_i ({tbl_bits.m2[q], tbl_bits.m1[q], tbl_bits.m0[q]}),
            .raddr_i (smp_data_i[q*QUAD_W +: QUAD_W]),
            .lvl_o   (lvl_v[q]),
            .c0_o    (c0_v[q]),
            .c1_o    (c1_v[q])
        );
    end

    // samples count only while armed and not being put on hold
    assign take = smp_valid_i && (state_q == ST_ARMED) && !hold_set;
    assign clr  = (state_q == ST_HELD) || hold_set;

    ltrg_combiner u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (tbl_we),
        .waddr_i (tbl_addr),
        .wbits_i ({tbl_bits.f4, tbl_bits.aux, tbl_bits.comb}),
        .take_i  (take),
        .clr_i   (clr),
        .lvl_i   (&lvl_v),
        .c0_i    (&c0_v),
        .c1_i    (&c1_v),
        .comb_o  (comb_hit),
        .final_o (final_hit)
    );

    ltrg_qual_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .take_i  (take),
        .final_i (final_hit),
        .comb_i  (comb_hit),
        .qsel_i  (qsel),
        .cmpa_i  (cmpa),
        .cmpb_i  (cmpb),
        .fire_o  (fire)
    );

    // next-state logic: release, trip, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD:  if (release_w) state_d = ST_ARMED;
            ST_ARMED: if (hold_set)  state_d = ST_HELD;
                      else if (fire) state_d = ST_FIRED;
            ST_FIRED: if (hold_set)  state_d = ST_HELD;
            default:  state_d = ST_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HELD;
        else        state_q <= state_d;
    end

    // output process
    assign trig_d = (state_q == ST_ARMED) && fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

    assign trig_o = trig_q;

    p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    p_fire_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (state_q == ST_FIRED));

    p_single_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRED) |=> !trig_o);

    p_held_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD) |=> !trig_o);

    p_hold_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !hold_q);

endmodule

// File: tb/tb_lut_trigger_core.sv
`timescale 1ns/1ps
module tb_lut_trigger_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [15:0] smp_data_i = '0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_addr_i = 1'b0;
    logic [7:0]  cfg_wdata_i = '0;
    logic        trig_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] t_m2 [4];
    logic [15:0] t_m1 [4];
    logic [15:0] t_m0 [4];
    logic [15:0] t_cq, t_ax, t_fn;

    always #2 clk = ~clk;

    lut_trigger_core dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid_i),
        .smp_data_i  (smp_data_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .trig_o      (trig_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: trig_o=%0d expected %0d", tag, act, exp);
        end
    endtask

    // level table entry for quad q: bit idx cleared when a masked channel disagrees
    function automatic logic [15:0] vm_entry(input int q, input logic [15:0] val,
                                              input logic [15:0] msk);
        logic [15:0] e = 16'hFFFF;
        for (int idx = 0; idx < 16; idx++)
            for (int b = 0; b < 4; b++)
                if (msk[4*q+b] && (val[4*q+b] != idx[b])) e[idx] = 1'b0;
        return e;
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(posedge clk); #1;
        cfg_we_i = 1'b0;
    endtask

    task automatic smp(input logic [15:0] d, input logic exp, input string tag);
        @(negedge clk);
        smp_valid_i = 1'b1; smp_data_i = d;
        @(posedge clk); #1;
        smp_valid_i = 1'b0;
        chk(trig_o, exp, tag);
    endtask

    task automatic plain_tables();
        for (int q = 0; q < 4; q++) begin
            t_m2[q] = 16'hFFFF; t_m1[q] = 16'hFFFF; t_m0[q] = 16'hFFFF;
        end
        t_cq = 16'hFFFF; t_ax = 16'h0000; t_fn = 16'hA000;
    endtask

    task automatic load_tables();
        for (int k = 0; k < 16; k++) begin
            wr(1'b0, {1'b0, t_fn[k], t_ax[k], t_cq[k],
                      t_m2[3][k], t_m2[2][k], t_m2[1][k], t_m2[0][k]});
            wr(1'b0, {t_m1[3][k], t_m1[2][k], t_m1[1][k], t_m1[0][k],
                      t_m0[3][k], t_m0[2][k], t_m0[1][k], t_m0[0][k]});
            wr(1'b1, 8'h30 | 8'(k));
        end
    endtask

    task automatic load_params(input logic [7:0] sel, input logic [15:0] cb,
                               input logic [15:0] ca);
        wr(1'b0, 8'h00);
        wr(1'b0, sel);
        wr(1'b0, cb[15:8]); wr(1'b0, cb[7:0]);
        wr(1'b0, ca[15:8]); wr(1'b0, ca[7:0]);
        wr(1'b1, 8'h60);
    endtask

    task automatic t_reset();
        chk(trig_o, 1'b0, "R1 reset value");
        smp(16'hFFFF, 1'b0, "R11 held sample ignored");
        wr(1'b1, 8'h00);
        smp(16'h0000, 1'b0, "R1 zero tables");
        smp(16'hFFFF, 1'b0, "R1 zero tables second");
    endtask

    task automatic t_value_mask();
        plain_tables();
        for (int q = 0; q < 4; q++) t_m2[q] = vm_entry(q, 16'h0035, 16'h00FF);
        load_tables();
        wr(1'b1, 8'h00);
        smp(16'h0035, 1'b0, "R6 no history on first sample");
        smp(16'h0036, 1'b0, "R4 masked mismatch");
        smp(16'hFF35, 1'b1, "R4 R12 match fires with default params");
        smp(16'h0035, 1'b0, "R10 once per arm");
        wr(1'b1, 8'h20); wr(1'b1, 8'h00);
        smp(16'h0035, 1'b0, "R10 rearm history restart");
        smp(16'h0035, 1'b1, "R10 rearm fires again");
    endtask

    task automatic t_count_cmpa();
        load_params(8'h70, 16'h0000, 16'h0002);
        wr(1'b1, 8'h00);
        smp(16'h0035, 1'b0, "R7 history sample");
        smp(16'h0035, 1'b0, "R9 count 0 below A");
        smp(16'h0036, 1'b0, "R8 miss does not count");
        smp(16'h0035, 1'b0, "R9 count 1 below A");
        smp(16'h0035, 1'b1, "R9 count 2 reaches A");
    endtask

    task automatic t_edge_rise();
        plain_tables();
        for (int q = 0; q < 4; q++) t_m0[q] = vm_entry(q, 16'h0020, 16'h0020);
        t_cq = 16'h2222;
        load_tables();
        load_params(8'h70, 16'h0000, 16'h0000);
        wr(1'b1, 8'h00);
        smp(16'h0020, 1'b0, "R5 rise ignored without history");
        smp(16'h0020, 1'b0, "R5 steady high");
        smp(16'h0000, 1'b0, "R5 fall is not rise");
        smp(16'h0020, 1'b1, "R5 rise on channel 5");
    endtask

    task automatic t_edge_fall();
        plain_tables();
        for (int q = 0; q < 4; q++) t_m1[q] = vm_entry(q, 16'h0400, 16'h0400);
        t_cq = 16'h0F00;
        load_tables();
        wr(1'b1, 8'h00);
        smp(16'h0000, 1'b0, "R5 edge-1 history");
        smp(16'h0400, 1'b0, "R5 rise is not fall");
        smp(16'h0000, 1'b1, "R5 fall on channel 10");
    endtask

    task automatic t_always_count();
        load_params(8'h34, 16'h0000, 16'h0003);
        wr(1'b1, 8'h00);
        smp(16'h0000, 1'b0, "R9 mode1 count 0");
        smp(16'h0000, 1'b0, "R9 mode1 count 1");
        smp(16'h0000, 1'b0, "R8 mode1 count 2");
        smp(16'h0000, 1'b1, "R8 R9 mode1 count 3 fires");
    endtask

    task automatic ch0_tables();
        plain_tables();
        for (int q = 0; q < 4; q++) t_m2[q] = vm_entry(q, 16'h0001, 16'h0001);
        load_tables();
    endtask

    task automatic t_reset_src();
        ch0_tables();
        load_params(8'h14, 16'h0000, 16'h0002);
        wr(1'b1, 8'h00);
        smp(16'h0000, 1'b0, "R8 count to 1");
        smp(16'h0001, 1'b0, "R8 final hit clears count");
        smp(16'h0000, 1'b0, "R8 count to 1 again");
        smp(16'h0000, 1'b0, "R8 count to 2");
        smp(16'h0000, 1'b1, "R8 fires after clear");
    endtask

    task automatic t_mode_b();
        load_params(8'h78, 16'h0001, 16'hFFFF);
        wr(1'b1, 8'h00);
        smp(16'h0001, 1'b0, "R9 mode2 history");
        smp(16'h0001, 1'b0, "R9 mode2 below B");
        smp(16'h0001, 1'b1, "R9 mode2 reaches B");
    endtask

    task automatic t_coincide();
        load_params(8'h70, 16'h0000, 16'h0000);
        wr(1'b1, 8'h00);
        smp(16'h0001, 1'b0, "R11 history before clash");
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = 1'b1; cfg_wdata_i = 8'h20;
        smp_valid_i = 1'b1; smp_data_i = 16'h0001;
        @(posedge clk); #1;
        cfg_we_i = 1'b0; smp_valid_i = 1'b0;
        chk(trig_o, 1'b0, "R11 hold wins same cycle");
        @(posedge clk); #1;
        chk(trig_o, 1'b0, "R11 no late pulse");
        wr(1'b1, 8'h00);
        smp(16'h0001, 1'b0, "R11 history cleared by hold");
        smp(16'h0001, 1'b1, "R11 fires after release");
    endtask

    task automatic t_held();
        plain_tables();
        load_tables();
        smp(16'h1234, 1'b0, "R11 held ignores");
        smp(16'h1234, 1'b0, "R11 held ignores again");
        wr(1'b1, 8'h00);
        smp(16'h1234, 1'b0, "R11 held samples left no history");
        smp(16'h1234, 1'b1, "R2 R3 all-match tables fire");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: trig_o=%0d expected run end", trig_o);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_value_mask();
        t_count_cmpa();
        t_edge_rise();
        t_edge_fall();
        t_always_count();
        t_reset_src();
        t_mode_b();
        t_coincide();
        t_held();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule